// File: doc/BRIEF.md
# Diagnostic-Port Text Stream Decoder

This block watches writes to the four byte-wide diagnostic ports that firmware uses for progress codes. The ports are numbered 0 to 3, where port 0 is the least significant byte of a 32-bit code and port 3 is the most significant. A four-byte code is complete when port 0 is written after each of ports 1, 2 and 3 has been written since the previous port-0 write. Completed codes are normally passed on unchanged as progress codes.

Firmware can also hide a text console in the same ports. A complete code equal to ASCII "_STR" (0x5F535452) opens a message. Each later write to port 0 on its own carries one character. The message closes when the code is rewritten to ASCII "_END" (0x5F454E44), with the upper ports written first and port 0 last. Characters leave on a one-byte valid/ready stream that carries start-of-message and end-of-message flags. A write to the upper ports that does not end in a proper end marker abandons the message and sets an error flag.

Top module: `postcon_decoder`

## Requirements
- R1: After reset, chr_valid, chr_sof, chr_eof, code_valid, msg_err and chr_ovf are all 0.
- R2: Outside a message, a complete code other than 0x5F535452 or 0x5F454E44 drives code_valid high for exactly one cycle. This happens in the cycle after the port-0 write, with code_data = {port3, port2, port1, port0}.
- R3: A port-0 write with at least one of ports 1–3 not written since the previous port-0 write produces no code output and opens no message.
- R4: A complete code equal to 0x5F535452 opens a message and is not forwarded as a code. A complete code equal to 0x5F454E44 outside a message is neither forwarded nor acted on.
- R5: Inside a message, each port-0 write produces one beat with chr_data equal to the written byte, in the cycle after the write. Only the first character beat of a message has chr_sof = 1.
- R6: Inside a message, writes to ports 1–3 followed by a port-0 write that completes 0x5F454E44 produce one beat with chr_eof = 1, chr_sof = 0 and chr_data = 0. The decoder then forwards codes again.
- R7: Inside a message, upper-port writes followed by a port-0 write that does not complete 0x5F454E44 abort the message. This sets msg_err, produces no beat, and returns the decoder to forwarding codes.
- R8: A beat with chr_ready low keeps chr_valid, chr_data, chr_sof and chr_eof unchanged. A new beat that arrives while one is pending and not being accepted is dropped and sets chr_ovf.
- R9: msg_err and chr_ovf stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | A diagnostic port write is present this cycle |
| wr_port | input | 2 | Port number 0–3 (0 = least significant byte) |
| wr_data | input | 8 | Byte written |
| chr_ready | input | 1 | Consumer accepts the current beat |
| chr_valid | output | 1 | A beat is pending |
| chr_data | output | 8 | Character byte (0 on an end beat) |
| chr_sof | output | 1 | First character of a message |
| chr_eof | output | 1 | End-of-message beat |
| chr_ovf | output | 1 | Sticky: a beat was dropped |
| code_valid | output | 1 | One-cycle pulse with a forwarded code |
| code_data | output | 32 | Forwarded four-byte code |
| msg_err | output | 1 | Sticky: a message was aborted |

## Verification
The hardest situation to reach from the ports is the end-marker check. An upper-port write during an open message has to be held back, and the decision is made only on the next port-0 write. The bench reaches this state with full end markers, with markers that have one wrong byte, and with markers that are missing an upper-port write. After each case it sends an ordinary code, so the return to forwarding shows at the ports. Near-exhaustive sweeps of the low byte under marker-like upper bytes show that only the exact markers are treated as markers.

// File: rtl/postcon_pkg.sv
package postcon_pkg;
  localparam int BYTE_W = 8;
  localparam int N_PORTS = 4;
  localparam int CODE_W = BYTE_W * N_PORTS;
  localparam logic [CODE_W-1:0] MARK_OPEN  = 32'h5F53_5452;
  localparam logic [CODE_W-1:0] MARK_CLOSE = 32'h5F45_4E44;

  typedef enum logic [1:0] {ST_IDLE, ST_TEXT, ST_CHECK} con_state_e;

  function automatic logic [CODE_W-1:0] join_code(
      input logic [CODE_W-BYTE_W-1:0] upper, input logic [BYTE_W-1:0] low);
    return {upper, low};
  endfunction

  function automatic logic is_mark(input logic full, input logic [CODE_W-1:0] code,
                                   input logic [CODE_W-1:0] mark);
    return full && (code == mark);
  endfunction
endpackage

// File: rtl/postcon_shadow.sv
module postcon_shadow #(
  parameter int BW = 8,
  parameter int NP = 4,
  localparam int UW = BW * (NP - 1),
  localparam int PW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_port,
  input  logic [BW-1:0] wr_data,
  output logic [UW-1:0] up_bytes,
  output logic          up_full,
  output logic          low_wr,
  output logic          up_wr
);
  logic [NP-1:1] seen;

  assign low_wr = wr_en && (wr_port == '0);
  assign up_wr  = wr_en && (wr_port != '0);
  assign up_full = &seen;

  for (genvar g = 1; g < NP; g++) begin : g_port
    logic [BW-1:0] byte_q;
    logic          seen_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        byte_q <= '0;
        seen_q <= 1'b0;
      end else if (wr_en && wr_port == PW'(g)) begin
        byte_q <= wr_data;
        seen_q <= 1'b1;
      end else if (low_wr) begin
        seen_q <= 1'b0;
      end
    end
    assign up_bytes[(g-1)*BW +: BW] = byte_q;
    assign seen[g] = seen_q;
  end
endmodule

// File: rtl/postcon_fsm.sv
module postcon_fsm
  import postcon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              low_wr,
  input  logic              up_wr,
  input  logic              up_full,
  input  logic [CODE_W-1:0] code,
  output logic              open_ev,
  output logic              char_ev,
  output logic              end_ev,
  output logic              abort_ev,
  output logic              code_ev,
  output logic              first_q,
  output logic              err_q
);
  con_state_e state_q;
  logic is_open, is_close;

  assign is_open  = is_mark(up_full, code, MARK_OPEN);
  assign is_close = is_mark(up_full, code, MARK_CLOSE);

  assign open_ev  = (state_q == ST_IDLE)  && low_wr && is_open;
  assign code_ev  = (state_q == ST_IDLE)  && low_wr && up_full && !is_open && !is_close;
  assign char_ev  = (state_q == ST_TEXT)  && low_wr;
  assign end_ev   = (state_q == ST_CHECK) && low_wr && is_close;
  assign abort_ev = (state_q == ST_CHECK) && low_wr && !is_close;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:  if (open_ev) state_q <= ST_TEXT;
        ST_TEXT:  if (up_wr) state_q <= ST_CHECK;
        ST_CHECK: if (low_wr) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
      if (open_ev) first_q <= 1'b1;
      else if (char_ev || end_ev || abort_ev) first_q <= 1'b0;
      if (abort_ev) err_q <= 1'b1;
    end
  end

  // R5: while text flows the upper ports still carry the opening prefix
  a_r5_text_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TEXT) |-> (code[CODE_W-1:BYTE_W] == MARK_OPEN[CODE_W-1:BYTE_W]));
  // R4: at most one decode event per write
  a_r4_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({open_ev, char_ev, end_ev, abort_ev, code_ev}));
  // R9: abort flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/postcon_emit.sv
module postcon_emit #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_char,
  input  logic          ev_end,
  input  logic [BW-1:0] ev_data,
  input  logic          ev_sof,
  input  logic          ready,
  output logic          valid,
  output logic [BW-1:0] data,
  output logic          sof,
  output logic          eof,
  output logic          ovf
);
  logic load_ev, stall;
  assign load_ev = ev_char || ev_end;
  assign stall   = valid && !ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      sof   <= 1'b0;
      eof   <= 1'b0;
      ovf   <= 1'b0;
    end else if (load_ev) begin
      if (stall) begin
        ovf <= 1'b1;
      end else begin
        valid <= 1'b1;
        data  <= ev_end ? '0 : ev_data;
        sof   <= ev_char && ev_sof;
        eof   <= ev_end;
      end
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R8: a stalled beat holds still
  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> valid && $stable(data) && $stable(sof) && $stable(eof));
  // R9: overflow flag is sticky
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R6: start and end flags never share a beat
  a_r6_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !(sof && eof));
endmodule

// File: rtl/postcon_decoder.sv
module postcon_decoder
  import postcon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_port,
  input  logic [7:0]        wr_data,
  input  logic              chr_ready,
  output logic              chr_valid,
  output logic [7:0]        chr_data,
  output logic              chr_sof,
  output logic              chr_eof,
  output logic              chr_ovf,
  output logic              code_valid,
  output logic [31:0]       code_data,
  output logic              msg_err
);
  localparam int UW = BYTE_W * (N_PORTS - 1);

  logic [UW-1:0]     up_bytes;
  logic              up_full, low_wr, up_wr;
  logic [CODE_W-1:0] code_now;
  logic              open_ev, char_ev, end_ev, abort_ev, code_ev, first_q;

  postcon_shadow #(.BW(BYTE_W), .NP(N_PORTS)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .up_bytes(up_bytes), .up_full(up_full), .low_wr(low_wr), .up_wr(up_wr));

  assign code_now = join_code(up_bytes, wr_data);

  postcon_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .low_wr(low_wr), .up_wr(up_wr), .up_full(up_full),
    .code(code_now), .open_ev(open_ev), .char_ev(char_ev), .end_ev(end_ev),
    .abort_ev(abort_ev), .code_ev(code_ev), .first_q(first_q), .err_q(msg_err));

  postcon_emit #(.BW(BYTE_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .ev_char(char_ev), .ev_end(end_ev), .ev_data(wr_data),
    .ev_sof(first_q), .ready(chr_ready), .valid(chr_valid), .data(chr_data),
    .sof(chr_sof), .eof(chr_eof), .ovf(chr_ovf));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_valid <= 1'b0;
      code_data  <= '0;
    end else begin
      code_valid <= code_ev;
      if (code_ev) code_data <= code_now;
    end
  end

  // R2 / R4: markers never leave on the code output
  a_r2_no_marker_code: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> (code_data != MARK_OPEN) && (code_data != MARK_CLOSE));
  // R2: a forwarded code is a single-cycle pulse per port-0 write
  a_r2_code_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> $past(wr_en) && ($past(wr_port) == 2'd0));
endmodule

// File: tb/sim_postcon_decoder.sv
module sim_postcon_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_port = '0;
  logic [7:0] wr_data = '0;
  logic chr_ready = 1'b1;
  logic chr_valid, chr_sof, chr_eof, chr_ovf, code_valid, msg_err;
  logic [7:0] chr_data;
  logic [31:0] code_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] OPEN_M  = 32'h5F535452;
  localparam logic [31:0] CLOSE_M = 32'h5F454E44;

  always #10 clk = ~clk;

  postcon_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .chr_ready(chr_ready), .chr_valid(chr_valid), .chr_data(chr_data), .chr_sof(chr_sof),
    .chr_eof(chr_eof), .chr_ovf(chr_ovf), .code_valid(code_valid), .code_data(code_data),
    .msg_err(msg_err));

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_port = p; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send_code(input logic [31:0] v);
    wr(2'd3, v[31:24]); wr(2'd2, v[23:16]); wr(2'd1, v[15:8]); wr(2'd0, v[7:0]);
  endtask

  task automatic expect_code(input logic [31:0] v, input string r);
    send_code(v);
    chk(code_valid === 1'b1, r, {31'd0, code_valid}, 32'd1);
    chk(code_data === v, r, code_data, v);
    @(negedge clk);
    chk(code_valid === 1'b0, r, {31'd0, code_valid}, 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk({chr_valid, chr_sof, chr_eof, code_valid, msg_err, chr_ovf} === 6'b0, "R1",
        {26'd0, chr_valid, chr_sof, chr_eof, code_valid, msg_err, chr_ovf}, 32'd0);

    // R2 sweep of ordinary codes
    for (int b = 0; b < 256; b++) begin
      logic [7:0] x;
      x = 8'(b);
      expect_code({x, x ^ 8'hA5, ~x, x + 8'd3}, "R2");
    end

    // R3 every incomplete upper-port mask
    for (int m = 0; m < 7; m++) begin
      for (int p = 1; p < 4; p++)
        if (m[p-1]) wr(2'(p), 8'h11 * 8'(p));
      wr(2'd0, 8'h52);
      chk(code_valid === 1'b0, "R3", {31'd0, code_valid}, 32'd0);
      chk(chr_valid === 1'b0, "R3", {31'd0, chr_valid}, 32'd0);
      // a plain code afterwards proves no message was opened
      expect_code(32'h0102_0300 + 32'(m), "R3");
    end

    // R4 sweep low byte under the opening prefix and under the closing prefix
    for (int b = 0; b < 256; b++) begin
      logic [7:0] x;
      x = 8'(b);
      if ({24'h5F5354, x} == OPEN_M) begin
        send_code(OPEN_M);
        chk(code_valid === 1'b0, "R4", {31'd0, code_valid}, 32'd0);
        send_code(CLOSE_M);
        chk(chr_valid && chr_eof && !chr_sof, "R6", {29'd0, chr_valid, chr_eof, chr_sof}, 32'd6);
      end else begin
        expect_code({24'h5F5354, x}, "R4");
      end
      if ({24'h5F454E, x} == CLOSE_M) begin
        send_code(CLOSE_M);
        chk(code_valid === 1'b0 && chr_valid === 1'b0, "R4", {30'd0, code_valid, chr_valid}, 32'd0);
      end else begin
        expect_code({24'h5F454E, x}, "R4");
      end
    end

    // R5 all 256 characters in one message, R6 close
    send_code(OPEN_M);
    for (int c = 0; c < 256; c++) begin
      wr(2'd0, 8'(c));
      chk(chr_valid === 1'b1 && chr_data === 8'(c), "R5", {24'd0, chr_data}, 32'(c));
      chk(chr_sof === (c == 0), "R5", {31'd0, chr_sof}, {31'd0, c == 0});
      chk(chr_eof === 1'b0, "R5", {31'd0, chr_eof}, 32'd0);
    end
    send_code(CLOSE_M);
    chk(chr_valid && chr_eof && !chr_sof && chr_data == 8'h00, "R6",
        {chr_data, 21'd0, chr_valid, chr_eof, chr_sof}, 32'd6);
    expect_code(32'hDEAD_BEEF, "R6");

    // R7 abort variants: one wrong byte, missing upper write, opening marker
    for (int k = 0; k < 3; k++) begin
      do_reset();
      send_code(OPEN_M);
      wr(2'd0, 8'h41);
      if (k == 0) send_code(32'h5F454E45);
      if (k == 1) begin wr(2'd1, 8'h4E); wr(2'd0, 8'h44); end
      if (k == 2) send_code(OPEN_M);
      chk(msg_err === 1'b1, "R7", {31'd0, msg_err}, 32'd1);
      chk(chr_valid === 1'b0, "R7", {31'd0, chr_valid}, 32'd0);
      expect_code(32'h0000_00A0 + 32'(k), "R7");
      chk(msg_err === 1'b1, "R9", {31'd0, msg_err}, 32'd1);
    end

    // R8 stall and overflow
    do_reset();
    chr_ready = 1'b0;
    send_code(OPEN_M);
    wr(2'd0, 8'h61);
    repeat (3) @(negedge clk);
    chk(chr_valid && chr_data == 8'h61 && chr_sof, "R8", {24'd0, chr_data}, 32'h61);
    chk(chr_ovf === 1'b0, "R8", {31'd0, chr_ovf}, 32'd0);
    wr(2'd0, 8'h62);
    chk(chr_ovf === 1'b1, "R8", {31'd0, chr_ovf}, 32'd1);
    chk(chr_data === 8'h61 && chr_sof === 1'b1, "R8", {24'd0, chr_data}, 32'h61);
    chr_ready = 1'b1;
    @(negedge clk);
    chk(chr_valid === 1'b0, "R8", {31'd0, chr_valid}, 32'd0);
    wr(2'd0, 8'h63);
    chk(chr_data === 8'h63 && chr_sof === 1'b0, "R8", {24'd0, chr_data}, 32'h63);
    send_code(CLOSE_M);
    chk(chr_eof === 1'b1, "R6", {31'd0, chr_eof}, 32'd1);
    expect_code(32'h1234_5678, "R9");
    chk(chr_ovf === 1'b1, "R9", {31'd0, chr_ovf}, 32'd1);
    do_reset();
    chk(chr_ovf === 1'b0 && msg_err === 1'b0, "R1", {30'd0, chr_ovf, msg_err}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule